// File: doc/BRIEF.md
# Bit-6 Address Swizzle Unit

This block reproduces the channel-interleave address swizzle that a memory system applies to byte address bit 6 when it reads tiled surfaces. A three-bit mode code selects which higher address bits (9, 10, 11 and 17, in fixed combinations) are XORed into bit 6. Every other address bit passes through unchanged. One mode code means "unknown": the address is not changed, and an error flag tells the caller that tiled access must not be used.

A mode-selection helper turns a description of the memory channels into one mode for X-tiled surfaces and one for Y-tiled surfaces. The description is either a configuration word that gives the channel arrangement and the channel-XOR options, or a direct comparison of the populated sizes of the two channels. A configuration word that reads as all ones is treated as a failed read. Both modes then become unknown and tiling is flagged as off.

A streaming page fix-up path carries a 4 KB page as 64-bit words with valid/ready handshakes. When the page's current physical bit 17 differs from the bit 17 recorded for it, the path swaps the two 64-byte halves of every 128-byte block. It buffers only the first half of each block to do this.

Top module: `swz_unit`

## Requirements
- R1: Address mode codes: 0 none, 1 bit9, 2 bit9^bit10, 3 bit9^bit11, 4 bit9^bit10^bit11, 5 bit9^bit17, 6 bit9^bit10^bit17, 7 unknown. `addrOut[6]` equals `addrIn[6]` XOR the bits that the mode names (XOR with 0 for codes 0 and 7).
- R2: All `addrOut` bits other than bit 6 equal the same bits of `addrIn`, in every mode.
- R3: With mode 7, `addrOut` equals `addrIn` and `addrErr` is 1. With any other mode, `addrErr` is 0.
- R4: With `sizeCompare`=0 and `cfgWord` not all ones, the channel arrangement is `cfgWord[1:0]`. Code 0 (single channel) and code 1 (dual asymmetric) give `xMode`=`yMode`=0. Code 3 is reserved and gives `xMode`=`yMode`=7.
- R5: Arrangement code 2 (dual interleaved) with `cfgWord[2]`=1 (channel XOR off) gives `xMode`=2 and `yMode`=1.
- R6: Arrangement code 2 with `cfgWord[2]`=0 gives `xMode`=4 and `yMode`=3 when `cfgWord[3]`=0 (XOR on bit 11), and `xMode`=6 and `yMode`=5 when `cfgWord[3]`=1 (XOR on bit 17).
- R7: With `sizeCompare`=1, `cfgWord` is ignored. Equal `ch0Size` and `ch1Size` give `xMode`=2 and `yMode`=1; unequal sizes give 0 and 0.
- R8: With `sizeCompare`=0 and `cfgWord` all ones, both modes are 7. `tileOff` is 1 exactly when `xMode` is 7.
- R9: When `newBit17`!=`recBit17` at the first word of a page, the output order in every 16-word (128-byte) block of that 512-word page is input words 8..15, then input words 0..7.
- R10: When `newBit17`==`recBit17` at the first word of a page, the words of that page leave in their input order.
- R11: The swap decision is taken at the first word of each page and held for the whole page. Changes to `newBit17` or `recBit17` later in the page have no effect.
- R12: Under `outReady` stalls no word is lost, duplicated or changed. A stalled output keeps `outValid` and `outData`, and no extra word appears after the stream ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrIn | input | ADDR_W | Byte address to swizzle |
| addrMode | input | 3 | Swizzle mode code (R1) |
| addrOut | output | ADDR_W | Swizzled address |
| addrErr | output | 1 | Unknown mode in use |
| cfgWord | input | CFG_W | Channel configuration word |
| sizeCompare | input | 1 | Select the channel-size comparison instead of cfgWord |
| ch0Size | input | SIZE_W | Populated size of channel 0 |
| ch1Size | input | SIZE_W | Populated size of channel 1 |
| xMode | output | 3 | Mode for X-tiled surfaces |
| yMode | output | 3 | Mode for Y-tiled surfaces |
| tileOff | output | 1 | Tiling must be disabled |
| recBit17 | input | 1 | Recorded bit 17 of the page |
| newBit17 | input | 1 | Current physical bit 17 of the page |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Input word accepted when high with inValid |
| inData | input | WORD_W | Input page word |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Downstream ready |
| outData | output | WORD_W | Output page word |

## Verification
The address path and the mode helper are combinational, so a wrong selection shows at the outputs in the same cycle. An exhaustive sweep of the relevant address bits and configuration fields catches it at once. In the page path the hidden state is the page word counter, the latched swap decision and the half-block buffer pointers. A slip in the buffer pointers corrupts words within eight outputs. A stale swap latch shows on the first block of the next page, and a counter off by one misplaces a page boundary in the second page of a continuous stream. The stream therefore runs four back-to-back pages with mid-page flag changes and irregular stalls.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [2:0] {
    SW_NONE      = 3'd0,
    SW_B9        = 3'd1,
    SW_B9_10     = 3'd2,
    SW_B9_11     = 3'd3,
    SW_B9_10_11  = 3'd4,
    SW_B9_17     = 3'd5,
    SW_B9_10_17  = 3'd6,
    SW_UNKNOWN   = 3'd7
  } swzMode_e;

  typedef enum logic [1:0] {
    ARR_SINGLE   = 2'd0,
    ARR_ASYM     = 2'd1,
    ARR_ILV      = 2'd2,
    ARR_RSVD     = 2'd3
  } memArr_e;

  // Strobes from the page control to the page datapath
  typedef struct packed {
    logic bufWr;   // store inData into the half buffer
    logic rdSel;   // drive outData from the half buffer
    logic rdAdv;   // advance the buffer read pointer
  } pageStrobe_t;

endpackage

// File: rtl/swz_addr.sv
module swz_addr
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [2:0]        modeIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrErr
);

  swzMode_e mode;
  logic     mixBit;

  assign mode = swzMode_e'(modeIn);

  always_comb begin
    unique case (mode)
      SW_B9:       mixBit = addrIn[9];
      SW_B9_10:    mixBit = addrIn[9] ^ addrIn[10];
      SW_B9_11:    mixBit = addrIn[9] ^ addrIn[11];
      SW_B9_10_11: mixBit = addrIn[9] ^ addrIn[10] ^ addrIn[11];
      SW_B9_17:    mixBit = addrIn[9] ^ addrIn[17];
      SW_B9_10_17: mixBit = addrIn[9] ^ addrIn[10] ^ addrIn[17];
      default:     mixBit = 1'b0;
    endcase
  end

  always_comb begin
    addrOut    = addrIn;
    addrOut[6] = addrIn[6] ^ mixBit;
  end

  assign addrErr = (mode == SW_UNKNOWN);

  // R2: only bit 6 may differ between input and output
  a_r2_other_bits_kept: assert property (@(posedge clk) disable iff (!rstN)
    ((addrOut ^ addrIn) & ~(ADDR_W'(1) << 6)) == '0);

  // R3: unknown mode leaves the address untouched and flags an error
  a_r3_unknown_passes: assert property (@(posedge clk) disable iff (!rstN)
    (modeIn == 3'd7) |-> (addrErr && addrOut == addrIn));

  // R1: single-bit mode folds bit 9 only
  a_r1_bit9_mode: assert property (@(posedge clk) disable iff (!rstN)
    (modeIn == 3'd1) |-> (addrOut[6] == (addrIn[6] ^ addrIn[9])));

endmodule

// File: rtl/swz_mode_pick.sv
module swz_mode_pick
  import swz_pkg::*;
#(
  parameter int CFG_W  = 32,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic              sizeCompare,
  input  logic [SIZE_W-1:0] ch0Size,
  input  logic [SIZE_W-1:0] ch1Size,
  output logic [2:0]        xMode,
  output logic [2:0]        yMode,
  output logic              tileOff
);

  localparam int XOR_OFF_BIT = 2;
  localparam int XOR_HI_BIT  = 3;

  swzMode_e xSel, ySel;
  logic     cfgDead;

  assign cfgDead = &cfgWord;

  always_comb begin
    xSel = SW_UNKNOWN;
    ySel = SW_UNKNOWN;
    if (sizeCompare) begin
      if (ch0Size == ch1Size) begin
        xSel = SW_B9_10;
        ySel = SW_B9;
      end else begin
        xSel = SW_NONE;
        ySel = SW_NONE;
      end
    end else if (!cfgDead) begin
      unique case (memArr_e'(cfgWord[1:0]))
        ARR_SINGLE, ARR_ASYM: begin
          xSel = SW_NONE;
          ySel = SW_NONE;
        end
        ARR_ILV: begin
          if (cfgWord[XOR_OFF_BIT]) begin
            xSel = SW_B9_10;
            ySel = SW_B9;
          end else if (!cfgWord[XOR_HI_BIT]) begin
            xSel = SW_B9_10_11;
            ySel = SW_B9_11;
          end else begin
            xSel = SW_B9_10_17;
            ySel = SW_B9_17;
          end
        end
        default: begin
          xSel = SW_UNKNOWN;
          ySel = SW_UNKNOWN;
        end
      endcase
    end
  end

  assign xMode   = xSel;
  assign yMode   = ySel;
  assign tileOff = (xSel == SW_UNKNOWN);

  // R8: a dead configuration word forbids tiling on both surface kinds
  a_r8_dead_cfg: assert property (@(posedge clk) disable iff (!rstN)
    (!sizeCompare && (&cfgWord)) |-> (xMode == 3'd7 && yMode == 3'd7 && tileOff));

  // R7: equal channel sizes pick the base interleave modes
  a_r7_equal_sizes: assert property (@(posedge clk) disable iff (!rstN)
    (sizeCompare && ch0Size == ch1Size) |-> (xMode == 3'd2 && yMode == 3'd1));

  // R8: the two modes are unknown together or not at all
  a_r8_unknown_paired: assert property (@(posedge clk) disable iff (!rstN)
    (xMode == 3'd7) == (yMode == 3'd7));

endmodule

// File: rtl/swz_page_ctrl.sv
module swz_page_ctrl
  import swz_pkg::*;
#(
  parameter int CNT_W   = 9,
  parameter int HALF_LG = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  input  logic        recBit17,
  input  logic        newBit17,
  output logic        inReady,
  output logic        outValid,
  output pageStrobe_t str
);

  localparam int DRAIN_LAST = (1 << HALF_LG) - 1;

  logic [CNT_W-1:0]   inCnt;
  logic [HALF_LG-1:0] drainCnt;
  logic               swapReg, draining;
  logic               pageStart, doSwap, blockEnd, inFire;

  assign pageStart = (inCnt == '0);
  assign doSwap    = pageStart ? (newBit17 ^ recBit17) : swapReg;
  assign blockEnd  = &inCnt[HALF_LG:0];

  always_comb begin
    str      = '0;
    inReady  = 1'b0;
    outValid = 1'b0;
    if (draining) begin
      outValid  = 1'b1;
      str.rdSel = 1'b1;
      str.rdAdv = outReady;
    end else if (doSwap && !inCnt[HALF_LG]) begin
      inReady   = 1'b1;
      str.bufWr = inValid;
    end else begin
      outValid = inValid;
      inReady  = outReady;
    end
  end

  assign inFire = inValid & inReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inCnt    <= '0;
      drainCnt <= '0;
      swapReg  <= 1'b0;
      draining <= 1'b0;
    end else begin
      if (inFire) begin
        inCnt <= inCnt + 1'b1;
        if (pageStart) swapReg <= doSwap;
        if (doSwap && blockEnd) begin
          draining <= 1'b1;
          drainCnt <= '0;
        end
      end
      if (draining && outReady) begin
        drainCnt <= drainCnt + 1'b1;
        if (drainCnt == HALF_LG'(DRAIN_LAST)) draining <= 1'b0;
      end
    end
  end

  // R9: the last word of a swapped block starts the buffered half
  a_r9_drain_follows_block: assert property (@(posedge clk) disable iff (!rstN)
    (inFire && doSwap && blockEnd && !draining) |=> (outValid && str.rdSel && !inReady));

  // R12: a stalled buffered word stays offered
  a_r12_drain_holds: assert property (@(posedge clk) disable iff (!rstN)
    (str.rdSel && !outReady) |=> (outValid && str.rdSel));

endmodule

// File: rtl/swz_page_dp.sv
module swz_page_dp
  import swz_pkg::*;
#(
  parameter int WORD_W     = 64,
  parameter int HALF_WORDS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pageStrobe_t       str,
  input  logic [WORD_W-1:0] inData,
  output logic [WORD_W-1:0] outData
);

  localparam int PTR_W = $clog2(HALF_WORDS);

  logic [WORD_W-1:0] halfBuf [HALF_WORDS];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (str.bufWr) halfBuf[wrPtr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (str.bufWr) wrPtr <= wrPtr + 1'b1;
      if (str.rdAdv) rdPtr <= rdPtr + 1'b1;
    end
  end

  assign outData = str.rdSel ? halfBuf[rdPtr] : inData;

  // R12: a stored word is what was on the input when it was written
  a_r12_buffer_capture: assert property (@(posedge clk) disable iff (!rstN)
    str.bufWr |=> (halfBuf[$past(wrPtr)] == $past(inData)));

  // R9: reading never overtakes writing within a block
  a_r9_read_behind_write: assert property (@(posedge clk) disable iff (!rstN)
    str.bufWr |-> !str.rdSel);

endmodule

// File: rtl/swz_unit.sv
module swz_unit
  import swz_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CFG_W      = 32,
  parameter int SIZE_W     = 16,
  parameter int WORD_W     = 64,
  parameter int PAGE_BYTES = 4096,
  parameter int HALF_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [2:0]        addrMode,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrErr,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic              sizeCompare,
  input  logic [SIZE_W-1:0] ch0Size,
  input  logic [SIZE_W-1:0] ch1Size,
  output logic [2:0]        xMode,
  output logic [2:0]        yMode,
  output logic              tileOff,
  input  logic              recBit17,
  input  logic              newBit17,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outData
);

  localparam int PAGE_WORDS = PAGE_BYTES * 8 / WORD_W;
  localparam int HALF_WORDS = HALF_BYTES * 8 / WORD_W;
  localparam int CNT_W      = $clog2(PAGE_WORDS);
  localparam int HALF_LG    = $clog2(HALF_WORDS);

  pageStrobe_t pageStr;

  swz_addr #(.ADDR_W(ADDR_W)) uAddr (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .modeIn(addrMode),
    .addrOut(addrOut), .addrErr(addrErr)
  );

  swz_mode_pick #(.CFG_W(CFG_W), .SIZE_W(SIZE_W)) uPick (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .sizeCompare(sizeCompare),
    .ch0Size(ch0Size), .ch1Size(ch1Size),
    .xMode(xMode), .yMode(yMode), .tileOff(tileOff)
  );

  swz_page_ctrl #(.CNT_W(CNT_W), .HALF_LG(HALF_LG)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .recBit17(recBit17), .newBit17(newBit17),
    .inReady(inReady), .outValid(outValid), .str(pageStr)
  );

  swz_page_dp #(.WORD_W(WORD_W), .HALF_WORDS(HALF_WORDS)) uDp (
    .clk(clk), .rstN(rstN), .str(pageStr), .inData(inData), .outData(outData)
  );

endmodule

// File: tb/tb_swz_unit.sv
module tb_swz_unit;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 64;
  localparam int PAGES  = 4;
  localparam int PWORDS = 512;
  localparam int TOTAL  = PAGES * PWORDS;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [2:0]        addrMode = '0;
  logic [ADDR_W-1:0] addrOut;
  logic              addrErr;
  logic [31:0]       cfgWord = '0;
  logic              sizeCompare = 1'b0;
  logic [15:0]       ch0Size = '0, ch1Size = '0;
  logic [2:0]        xMode, yMode;
  logic              tileOff;
  logic              recBit17 = 1'b0, newBit17 = 1'b0;
  logic              inValid = 1'b0, inReady, outValid, outReady = 1'b0;
  logic [WORD_W-1:0] inData = '0, outData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  swz_unit dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .addrMode(addrMode),
    .addrOut(addrOut), .addrErr(addrErr), .cfgWord(cfgWord),
    .sizeCompare(sizeCompare), .ch0Size(ch0Size), .ch1Size(ch1Size),
    .xMode(xMode), .yMode(yMode), .tileOff(tileOff),
    .recBit17(recBit17), .newBit17(newBit17), .inValid(inValid),
    .inReady(inReady), .inData(inData), .outValid(outValid),
    .outReady(outReady), .outData(outData)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic expMix(input int m, input logic [ADDR_W-1:0] a);
    case (m)
      1: return a[9];
      2: return a[9] ^ a[10];
      3: return a[9] ^ a[11];
      4: return a[9] ^ a[10] ^ a[11];
      5: return a[9] ^ a[17];
      6: return a[9] ^ a[10] ^ a[17];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] wordOf(input int p, input int i);
    return {32'(p) + 32'h0BAD_0000, 32'(i) ^ 32'h5A00_0000};
  endfunction

  function automatic logic pageNewBit(input int p, input int i);
    case (p)
      0: return 1'b1;
      1: return 1'b0;
      2: return (i < 100);
      default: return (i >= 100);
    endcase
  endfunction

  task automatic checkModes(input string tag, input int ex, input int ey);
    #1;
    check(xMode == 3'(ex) && yMode == 3'(ey), tag, {xMode, yMode}, {3'(ex), 3'(ey)});
    check(tileOff == (ex == 7), {tag, " R8 tileOff"}, 64'(tileOff), 64'(ex == 7));
  endtask

  task automatic producer();
    int i = 0;
    while (i < TOTAL) begin
      bit acc;
      @(negedge clk);
      inValid  = 1'b1;
      inData   = wordOf(i / PWORDS, i % PWORDS);
      recBit17 = 1'b0;
      newBit17 = pageNewBit(i / PWORDS, i % PWORDS);
      #1;
      acc = inReady;
      @(posedge clk);
      if (acc) i++;
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic consumer();
    int k = 0;
    int cyc = 0;
    bit prevStall = 1'b0;
    logic [WORD_W-1:0] prevData = '0;
    while (k < TOTAL) begin
      @(negedge clk);
      cyc++;
      outReady = !((cyc % 5) == 3 || (cyc >= 300 && cyc < 320));
      #2;
      if (prevStall) begin
        check(outValid && outData == prevData, "R12 stalled word held", outData, prevData);
      end
      prevStall = outValid && !outReady;
      prevData  = outData;
      if (outValid && outReady) begin
        int p   = k / PWORDS;
        int idx = k % PWORDS;
        bit sw  = (p == 0 || p == 2);
        int src = sw ? (idx ^ 8) : idx;
        logic [WORD_W-1:0] ex = wordOf(p, src);
        if (p == 2 || p == 3)
          check(outData == ex, "R11 flag held for page", outData, ex);
        else if (sw)
          check(outData == ex, "R9 swapped halves", outData, ex);
        else
          check(outData == ex, "R10 order kept", outData, ex);
        k++;
      end
    end
    @(negedge clk);
    outReady = 1'b1;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(outValid == 1'b0, "reset outValid low", 64'(outValid), 64'(0));
    check(addrErr == 1'b0 && addrOut == addrIn, "R3 reset mode none", addrOut, addrIn);

    // R1 R2 R3: sweep modes against bits 6, 9, 10, 11, 17
    for (int m = 0; m < 8; m++) begin
      for (int c = 0; c < 32; c++) begin
        logic [ADDR_W-1:0] a, ex;
        a = 32'hA5C3_1E4B ^ (32'(c) * 32'h0102_0408);
        a[6] = c[0]; a[9] = c[1]; a[10] = c[2]; a[11] = c[3]; a[17] = c[4];
        @(negedge clk);
        addrIn = a;
        addrMode = 3'(m);
        #1;
        ex = a;
        ex[6] = a[6] ^ expMix(m, a);
        check(addrOut == ex, "R1 R2 swizzled address", addrOut, ex);
        check(addrErr == (m == 7), "R3 error flag", 64'(addrErr), 64'(m == 7));
      end
    end

    // R4 R5 R6: configuration word fields
    sizeCompare = 1'b0;
    for (int f = 0; f < 16; f++) begin
      int ex, ey;
      @(negedge clk);
      cfgWord = {28'h5A5A5A5, 4'(f)};
      case (f & 3)
        0, 1: begin ex = 0; ey = 0; end
        2: begin
          if (f[2]) begin ex = 2; ey = 1; end
          else if (!f[3]) begin ex = 4; ey = 3; end
          else begin ex = 6; ey = 5; end
        end
        default: begin ex = 7; ey = 7; end
      endcase
      checkModes((f & 3) == 2 ? "R5 R6 interleaved modes" : "R4 arrangement modes", ex, ey);
    end

    // R8: dead configuration word
    @(negedge clk);
    cfgWord = '1;
    checkModes("R8 all ones word", 7, 7);

    // R7: size comparison overrides the word
    @(negedge clk);
    sizeCompare = 1'b1; ch0Size = 16'h0400; ch1Size = 16'h0400;
    checkModes("R7 equal sizes", 2, 1);
    @(negedge clk);
    ch1Size = 16'h0010;
    checkModes("R7 unequal sizes", 0, 0);
    @(negedge clk);
    cfgWord = 32'h0000_0006; ch1Size = 16'h0400;
    checkModes("R7 word ignored", 2, 1);

    // R9 R10 R11 R12: four back-to-back pages with stalls
    fork
      producer();
      consumer();
    join
    repeat (4) @(negedge clk);
    #2;
    check(outValid == 1'b0, "R12 no extra word", 64'(outValid), 64'(0));

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule